// File: doc/BRIEF.md
# Dual-Bank Pulse-Swallow Feedback Divider

This block is the digital half of a dual-modulus feedback divider for a frequency synthesizer. A prescaler outside the block divides the oscillator by either a low modulus N or by N+1. It reports each completed division as a one-cycle strobe, `preTick`, synchronous to `clk`. The block counts those strobes with a swallow counter and a main counter, and it drives `modHigh` back to the prescaler. It emits one `divPulse` per full feedback cycle, which the phase-frequency detector takes as its comparison edge. With swallow count A and main count P, one feedback cycle spans P prescaler periods. The first A of them use modulus N+1, so the oscillator is divided by P·N + A.

Two divide words are held as inputs, one per bank. A select bit picks the active bank. A pin-level override, when enabled, replaces that bit. A word is only taken in at a terminal count: edits to a word and bank switches never shorten or stretch a cycle already in progress. A word with A greater than P, or with P of zero, is illegal. The block still runs such a word in a defined way and raises `cfgErr` for that cycle.

Top module: `swallow_divider`

## Requirements
- R1: While `rstN` is low, `divPulse`, `modHigh` and `cfgErr` are 0 and `bankInUse` is 0.
- R2: With a prescaler that runs LOW_MOD+1 clocks per period while `modHigh` is 1 and LOW_MOD clocks otherwise, consecutive `divPulse` assertions are exactly P·LOW_MOD + A clock cycles apart for a legal word (A in bits [3:0], P in bits [9:0]).
- R3: After each terminal count, `modHigh` is 1 for exactly the first A prescaler periods of the new cycle and 0 for the rest, which is A·(LOW_MOD+1) clock cycles per feedback cycle.
- R4: `divPulse` is a single-cycle pulse. It is asserted in the cycle after the `preTick` that ends the P-th prescaler period.
- R5: The active bank is `selPin` when `selPinEn` is 1 and `selBit` otherwise, with 0 meaning bank 0 (`aWord0`/`pWord0`) and 1 meaning bank 1. `bankInUse` reports the bank that was loaded.
- R6: A change to either divide word or to the bank selection takes effect only at the next terminal count. The cycle in progress keeps its length, and `bankInUse` changes only together with `divPulse`.
- R7: If A exceeds P, `cfgErr` is 1 for that feedback cycle and A is treated as P, so the cycle lasts P·(LOW_MOD+1) clocks. A legal word clears `cfgErr` at its load.
- R8: A P of zero is treated as P = 1, with A limited to 1, and raises `cfgErr` for that cycle.
- R9: With no `preTick`, the counters hold. `modHigh` keeps its value and no `divPulse` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| preTick | input | 1 | One-cycle strobe when the prescaler completes a division |
| aWord0 | input | 4 | Bank 0 swallow count A |
| pWord0 | input | 10 | Bank 0 main count P |
| aWord1 | input | 4 | Bank 1 swallow count A |
| pWord1 | input | 10 | Bank 1 main count P |
| selBit | input | 1 | Programmed bank select |
| selPinEn | input | 1 | Enables the pin override of the bank select |
| selPin | input | 1 | Override bank select value |
| modHigh | output | 1 | Prescaler modulus control, 1 selects N+1 |
| divPulse | output | 1 | One-cycle pulse per feedback cycle |
| cfgErr | output | 1 | Loaded word was illegal and has been clamped |
| bankInUse | output | 1 | Bank whose word is currently running |

## Verification
The in-line assertions watch, on every cycle, the invariants the counters must keep. The swallow count never exceeds the main count. Counters and the reported bank move only on a load or a step strobe. `modHigh` drops only as the result of a strobe. An illegal word is loaded clamped with the error flag raised, and a pulse is always preceded by a prescaler strobe. The overall division ratio, the number of high-modulus periods, the deferral of word and bank changes to the terminal count, and the select-pin priority depend on closing the loop through a prescaler. Only the bench's scenarios can show these, using its cycle-accurate stub that measures pulse spacing and `modHigh` occupancy.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // take in the selected word
    logic step;  // one prescaler period consumed
  } divStrobe_t;
endpackage

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       preTick,
  input  logic       pLast,
  output divStrobe_t strb,
  output logic       divPulse
);
  logic primed;
  logic termCount;

  assign termCount = primed && preTick && pLast;

  always_comb begin
    strb.load = !primed || termCount;
    strb.step = primed && preTick && !pLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed   <= 1'b0;
      divPulse <= 1'b0;
    end else begin
      primed   <= 1'b1;
      divPulse <= termCount;
    end
  end

  // R4
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |-> $past(preTick));
endmodule

// File: rtl/swallow_dp.sv
module swallow_dp
  import swallow_div_pkg::*;
#(
  parameter int A_W = 4,
  parameter int P_W = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobe_t     strb,
  input  logic [A_W-1:0] aWord0,
  input  logic [P_W-1:0] pWord0,
  input  logic [A_W-1:0] aWord1,
  input  logic [P_W-1:0] pWord1,
  input  logic           bankSel,
  output logic           pLast,
  output logic           modHigh,
  output logic           cfgErr,
  output logic           bankInUse
);
  localparam int CMP_W = (A_W > P_W) ? A_W : P_W;

  logic [A_W-1:0]   aCnt;
  logic [P_W-1:0]   pCnt;
  logic [A_W-1:0]   selA;
  logic [P_W-1:0]   selP;
  logic [P_W-1:0]   pEff;
  logic [A_W-1:0]   aEff;
  logic [CMP_W-1:0] aWide;
  logic [CMP_W-1:0] pWide;
  logic             wordBad;

  assign selA  = bankSel ? aWord1 : aWord0;
  assign selP  = bankSel ? pWord1 : pWord0;
  assign pEff  = (selP == '0) ? P_W'(1) : selP;
  assign aWide = CMP_W'(selA);
  assign pWide = CMP_W'(pEff);
  assign aEff  = (aWide > pWide) ? A_W'(pEff) : selA;
  assign wordBad = (selP == '0) || (CMP_W'(selA) > CMP_W'(selP));

  assign pLast   = (pCnt == P_W'(1));
  assign modHigh = (aCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aCnt      <= '0;
      pCnt      <= '0;
      cfgErr    <= 1'b0;
      bankInUse <= 1'b0;
    end else if (strb.load) begin
      aCnt      <= aEff;
      pCnt      <= pEff;
      cfgErr    <= wordBad;
      bankInUse <= bankSel;
    end else if (strb.step) begin
      pCnt <= pCnt - P_W'(1);
      if (aCnt != '0) aCnt <= aCnt - A_W'(1);
    end
  end

  // R7
  a_within_p_chk: assert property (@(posedge clk) disable iff (!rstN)
    CMP_W'(aCnt) <= CMP_W'(pCnt));
  // R7
  clamp_on_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && selP != '0 && CMP_W'(selA) > CMP_W'(selP))
      |=> (CMP_W'(aCnt) == CMP_W'(pCnt) && cfgErr));
  // R9
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step) |=> ($stable(pCnt) && $stable(aCnt)));
  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(bankInUse));
  // R3
  mod_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(modHigh) |-> $past(strb.step || strb.load));
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_div_pkg::*;
#(
  parameter int A_W = 4,
  parameter int P_W = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           preTick,
  input  logic [A_W-1:0] aWord0,
  input  logic [P_W-1:0] pWord0,
  input  logic [A_W-1:0] aWord1,
  input  logic [P_W-1:0] pWord1,
  input  logic           selBit,
  input  logic           selPinEn,
  input  logic           selPin,
  output logic           modHigh,
  output logic           divPulse,
  output logic           cfgErr,
  output logic           bankInUse
);
  divStrobe_t strb;
  logic       pLast;
  logic       bankSel;

  // Pin override wins over the programmed select
  assign bankSel = selPinEn ? selPin : selBit;

  swallow_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .preTick  (preTick),
    .pLast    (pLast),
    .strb     (strb),
    .divPulse (divPulse)
  );

  swallow_dp #(.A_W(A_W), .P_W(P_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .aWord0    (aWord0),
    .pWord0    (pWord0),
    .aWord1    (aWord1),
    .pWord1    (pWord1),
    .bankSel   (bankSel),
    .pLast     (pLast),
    .modHigh   (modHigh),
    .cfgErr    (cfgErr),
    .bankInUse (bankInUse)
  );
endmodule

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_MOD    = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       preTick = 1'b0;
  logic [3:0] aWord0 = 4'd3, aWord1 = 4'd2;
  logic [9:0] pWord0 = 10'd10, pWord1 = 10'd6;
  logic       selBit = 1'b0, selPinEn = 1'b0, selPin = 1'b0;
  logic       modHigh, divPulse, cfgErr, bankInUse;
  logic       stubOn = 1'b0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider u0 (
    .clk(clk), .rstN(rstN), .preTick(preTick),
    .aWord0(aWord0), .pWord0(pWord0), .aWord1(aWord1), .pWord1(pWord1),
    .selBit(selBit), .selPinEn(selPinEn), .selPin(selPin),
    .modHigh(modHigh), .divPulse(divPulse), .cfgErr(cfgErr), .bankInUse(bankInUse)
  );

  // Cycle-accurate prescaler stub: period length chosen from modHigh at period start
  initial begin
    int sc = 0;
    int curLen = LOW_MOD;
    forever begin
      @(negedge clk);
      if (rstN && stubOn) begin
        if (preTick) begin
          preTick = 1'b0;
          curLen = modHigh ? LOW_MOD + 1 : LOW_MOD;
          sc = 1;
        end else begin
          sc++;
        end
        if (sc >= curLen) preTick = 1'b1;
      end else begin
        preTick = 1'b0;
        sc = 0;
        curLen = LOW_MOD;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic nextPulse();
    do @(negedge clk); while (!divPulse);
  endtask

  // Starts at a pulse negedge, ends at the next pulse negedge
  task automatic frame(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      if (modHigh) hi++;
      @(negedge clk);
      len++;
    end while (!divPulse);
  endtask

  task automatic setBank0(input int a, input int p);
    aWord0 = 4'(a); pWord0 = 10'(p);
    nextPulse();
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(divPulse == 0 && modHigh == 0 && cfgErr == 0 && bankInUse == 0,
        "R1 reset outputs", {modHigh, divPulse, cfgErr, bankInUse}, 0);
    rstN = 1'b1; stubOn = 1'b1;
    nextPulse();
  endtask

  task automatic testRatio(input int a, input int p);
    int len, hi;
    setBank0(a, p);
    frame(len, hi);
    chk(len == p * LOW_MOD + a, "R2 pulse spacing", len, p * LOW_MOD + a);
    chk(hi == a * (LOW_MOD + 1), "R3 high-modulus cycles", hi, a * (LOW_MOD + 1));
    @(negedge clk);
    chk(divPulse == 0, "R4 single-cycle pulse", divPulse, 0);
    chk(cfgErr == 0, "R7 legal word no error", cfgErr, 0);
  endtask

  task automatic testBankSelect();
    int len, hi;
    aWord0 = 4'd3; pWord0 = 10'd10; aWord1 = 4'd2; pWord1 = 10'd6;
    selBit = 1'b1; nextPulse();
    chk(bankInUse == 1, "R5 select bit bank1", bankInUse, 1);
    frame(len, hi);
    chk(len == 26, "R5 bank1 spacing", len, 26);
    selPinEn = 1'b1; selPin = 1'b0; nextPulse();
    chk(bankInUse == 0, "R5 pin override to bank0", bankInUse, 0);
    frame(len, hi);
    chk(len == 43, "R5 override spacing", len, 43);
    selPinEn = 1'b0; selBit = 1'b0; nextPulse();
  endtask

  task automatic testDeferred();
    int len, hi;
    setBank0(3, 10);
    nextPulse();
    repeat (7) @(negedge clk);
    pWord0 = 10'd12;
    do begin
      if (modHigh) hi++;
      @(negedge clk);
    end while (!divPulse);
    frame(len, hi);
    chk(len == 51, "R6 new word after terminal", len, 51);
    repeat (5) @(negedge clk);
    selBit = 1'b1;
    @(negedge clk);
    chk(bankInUse == 0, "R6 bank unchanged mid-cycle", bankInUse, 0);
    len = 6;
    while (!divPulse) begin @(negedge clk); len++; end
    chk(len == 51, "R6 running cycle kept length", len, 51);
    chk(bankInUse == 1, "R6 bank switched at pulse", bankInUse, 1);
    selBit = 1'b0; nextPulse();
  endtask

  task automatic testIllegal();
    int len, hi;
    setBank0(9, 5);
    chk(cfgErr == 1, "R7 error flag", cfgErr, 1);
    frame(len, hi);
    chk(len == 25, "R7 clamped spacing", len, 25);
    chk(hi == 25, "R7 clamped high cycles", hi, 25);
    setBank0(0, 0);
    chk(cfgErr == 1, "R8 zero P flagged", cfgErr, 1);
    frame(len, hi);
    chk(len == LOW_MOD, "R8 zero P spacing", len, LOW_MOD);
    setBank0(3, 0);
    frame(len, hi);
    chk(len == LOW_MOD + 1, "R8 zero P clamps A", len, LOW_MOD + 1);
    setBank0(2, 8);
    chk(cfgErr == 0, "R7 flag cleared by legal word", cfgErr, 0);
  endtask

  task automatic testHold();
    logic held;
    int pulses = 0, changes = 0;
    setBank0(5, 9);
    stubOn = 1'b0;
    @(negedge clk);
    held = modHigh;
    repeat (40) begin
      @(negedge clk);
      if (divPulse) pulses++;
      if (modHigh != held) changes++;
    end
    chk(pulses == 0, "R9 no pulse without ticks", pulses, 0);
    chk(changes == 0, "R9 modHigh held", changes, 0);
    stubOn = 1'b1;
    nextPulse(); nextPulse();
  endtask

  initial begin
    testReset();
    testRatio(3, 10);
    testRatio(0, 7);
    testRatio(15, 20);
    testRatio(1, 1);
    testBankSelect();
    testDeferred();
    testIllegal();
    testHold();
    summary();
    $finish;
  end
endmodule